// File: doc/BRIEF.md
# Command-Register APB Bridge

This block lets a host run single 32-bit transfers on an APB debug bus through one 64-bit control word. In a single host write the word carries a start flag, a direction flag, a 29-bit word address and 32 bits of data. The block then runs one APB transfer (setup phase, then an access phase held until the slave is ready) and clears the start flag when the transfer ends. The host polls the same word: the start flag doubles as a busy flag, bit 31 reports a slave error and, after a read, the upper 32 bits hold the returned word.

The word address carries a tile number in a fixed slice. Tile zero selects the root ROM-table region; any other tile must carry a marker bit as well. The block normalises the marker on every accepted host write, so the bus never sees an inconsistent address.

Top module: `cmd_apb_bridge`

## Requirements
- R1: After synchronous reset the control word reads 0, and PSEL and PENABLE are low.
- R2: A host write with bit 0 = 1 while bit 0 reads 0 is accepted: bit 0 reads 1 on the next cycle and PSEL rises one cycle later with PENABLE low. PWRITE is the inverse of bit 1 (0 = write, 1 = read), and PADDR is the stored 29-bit field (control bits 30:2) shifted left by 2.
- R3: A setup cycle (PSEL high, PENABLE low) is followed by exactly one access cycle start (PSEL and PENABLE high). The access phase, and PADDR, PWRITE and PWDATA, hold until PREADY is sampled high.
- R4: On the edge where PREADY is sampled high in the access phase, bit 0 clears and PSEL and PENABLE drop; bit 0 reads 1 for every cycle from acceptance until then.
- R5: PWDATA equals control bits 63:32. When a read ends, PRDATA is stored in bits 63:32; a write leaves them unchanged.
- R6: On every accepted host write, address field bit 28 (control bit 30) is set when field bits 27:24 (the tile, control bits 29:26) are nonzero and cleared when they are zero; the stored field reads back in this normalised form.
- R7: Bit 31 is set when PSLVERR is high on the completing edge and cleared when the transfer ends without error; an accepted write with bit 0 = 1 clears it.
- R8: A host write while bit 0 reads 1 is ignored: no field changes and no extra transfer starts.
- R9: A host write with bit 0 = 0 while idle stores bits 1, 30:2 and 63:32, starts no transfer, and leaves bit 31 unchanged whatever the written bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the control word |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Control word read-back |
| paddr | output | PADDR_W | APB byte address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction, 1 = write |
| pwdata | output | 32 | APB write data |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
The bench builds the block with its default parameters: a 32-bit PADDR, a four-bit tile slice at field bits 27:24 and the marker at field bit 28, which is the layout the requirements describe. With that layout random addresses hit both the root tile and all fifteen other tiles, including host words that carry a wrong marker, so the normalisation is seen in both directions. A bench slave inserts zero to seven wait states and errors on demand, which exercises the held access phase, error capture and clearing, and host writes that land in the middle of a transfer.

// File: rtl/cmd_apb_pkg.sv
package cmd_apb_pkg;
  // Control word layout (fixed by the host software contract).
  localparam int CTL_W       = 64;
  localparam int DATA_W      = 32;
  localparam int FIELD_W     = 29;
  localparam int BIT_GO      = 0;
  localparam int BIT_DIR     = 1;
  localparam int FIELD_LSB   = 2;
  localparam int BIT_ERR     = 31;
  localparam int DATA_LSB    = 32;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_e;

  typedef struct packed {
    logic [DATA_W-1:0]  data;
    logic               err;
    logic [FIELD_W-1:0] field;
    logic               dir;
    logic               go;
  } ctl_word_t;
endpackage

// File: rtl/tile_addr_norm.sv
module tile_addr_norm
  import cmd_apb_pkg::*;
#(
  parameter int TILE_LSB = 24,
  parameter int TILE_W   = 4,
  parameter int MARK_POS = 28,
  parameter bit MARK_EN  = 1'b1
) (
  input  logic [FIELD_W-1:0] field_in,
  output logic [FIELD_W-1:0] field_out
);
  localparam int TILE_MSB = TILE_LSB + TILE_W - 1;

  logic tile_nz;
  assign tile_nz = |field_in[TILE_MSB:TILE_LSB];

  generate
    if (MARK_EN) begin : g_mark
      always_comb begin
        field_out           = field_in;
        field_out[MARK_POS] = tile_nz;
      end
    end else begin : g_pass
      assign field_out = field_in;
    end
  endgenerate
endmodule

// File: rtl/apb_phase_fsm.sv
module apb_phase_fsm
  import cmd_apb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic pready,
  output logic psel,
  output logic penable,
  output logic done
);
  phase_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_IDLE:   if (launch) state_d = PH_SETUP;
      PH_SETUP:  state_d = PH_ACCESS;
      PH_ACCESS: if (pready) state_d = PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      psel    <= 1'b0;
      penable <= 1'b0;
    end else begin
      state_q <= state_d;
      psel    <= (state_d == PH_SETUP) || (state_d == PH_ACCESS);
      penable <= (state_d == PH_ACCESS);
    end
  end

  assign done = (state_q == PH_ACCESS) && pready;
endmodule

// File: rtl/cmd_word_reg.sv
module cmd_word_reg
  import cmd_apb_pkg::*;
#(
  parameter int TILE_LSB = 24,
  parameter int TILE_W   = 4,
  parameter int MARK_POS = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [CTL_W-1:0]  host_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              rd_err,
  output ctl_word_t         ctl_q,
  output logic              launch
);
  logic [FIELD_W-1:0] field_norm;
  logic               accept;

  tile_addr_norm #(
    .TILE_LSB(TILE_LSB),
    .TILE_W  (TILE_W),
    .MARK_POS(MARK_POS),
    .MARK_EN (1'b1)
  ) u_norm (
    .field_in (host_wdata[FIELD_LSB +: FIELD_W]),
    .field_out(field_norm)
  );

  assign accept = host_we && !ctl_q.go;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      launch <= 1'b0;
    end else begin
      launch <= accept && host_wdata[BIT_GO];
      if (done) begin
        ctl_q.go  <= 1'b0;
        ctl_q.err <= rd_err;
        if (ctl_q.dir) ctl_q.data <= rd_word;
      end else if (accept) begin
        ctl_q.dir   <= host_wdata[BIT_DIR];
        ctl_q.field <= field_norm;
        ctl_q.data  <= host_wdata[DATA_LSB +: DATA_W];
        if (host_wdata[BIT_GO]) begin
          ctl_q.go  <= 1'b1;
          ctl_q.err <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/cmd_apb_bridge.sv
module cmd_apb_bridge
  import cmd_apb_pkg::*;
#(
  parameter int PADDR_W  = 32,
  parameter int TILE_LSB = 24,
  parameter int TILE_W   = 4,
  parameter int MARK_POS = 28
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_we,
  input  logic [63:0]        host_wdata,
  output logic [63:0]        host_rdata,
  output logic [PADDR_W-1:0] paddr,
  output logic               psel,
  output logic               penable,
  output logic               pwrite,
  output logic [31:0]        pwdata,
  input  logic [31:0]        prdata,
  input  logic               pready,
  input  logic               pslverr
);
  localparam int BYTE_ADDR_W = FIELD_W + 2;

  ctl_word_t ctl_q;
  logic      launch;
  logic      done;
  logic [BYTE_ADDR_W-1:0] byte_addr;

  cmd_word_reg #(
    .TILE_LSB(TILE_LSB),
    .TILE_W  (TILE_W),
    .MARK_POS(MARK_POS)
  ) u_reg (
    .clk       (clk),
    .rst       (rst),
    .host_we   (host_we),
    .host_wdata(host_wdata),
    .done      (done),
    .rd_word   (prdata),
    .rd_err    (pslverr),
    .ctl_q     (ctl_q),
    .launch    (launch)
  );

  apb_phase_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .launch (launch),
    .pready (pready),
    .psel   (psel),
    .penable(penable),
    .done   (done)
  );

  assign byte_addr  = {ctl_q.field, 2'b00};
  assign paddr      = PADDR_W'(byte_addr);
  assign pwrite     = !ctl_q.dir;
  assign pwdata     = ctl_q.data;
  assign host_rdata = ctl_q;
endmodule

// File: rtl/cmd_apb_bridge_chk.sv
module cmd_apb_bridge_chk #(
  parameter int PADDR_W  = 32,
  parameter int TILE_LSB = 24,
  parameter int TILE_W   = 4,
  parameter int MARK_POS = 28
) (
  input logic               clk,
  input logic               rst,
  input logic               host_we,
  input logic [63:0]        host_rdata,
  input logic [PADDR_W-1:0] paddr,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [31:0]        pwdata,
  input logic               pready,
  input logic               pslverr
);
  logic fin;
  assign fin = psel && penable && pready;

  assert_setup_to_access_R3: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));

  assert_access_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr)
                                      && $stable(pwrite) && $stable(pwdata)));

  assert_enable_needs_sel_R3: assert property (@(posedge clk) disable iff (rst)
    penable |-> psel);

  assert_busy_during_bus_R4: assert property (@(posedge clk) disable iff (rst)
    psel |-> host_rdata[0]);

  assert_go_clears_R4: assert property (@(posedge clk) disable iff (rst)
    fin |=> (!host_rdata[0] && !psel));

  assert_err_capture_R7: assert property (@(posedge clk) disable iff (rst)
    fin |=> (host_rdata[31] == $past(pslverr)));

  assert_tile_marker_R6: assert property (@(posedge clk) disable iff (rst)
    psel |-> ((|paddr[TILE_LSB+2 +: TILE_W]) == paddr[MARK_POS+2]));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (host_we && host_rdata[0] && !fin) |=> $stable(host_rdata));
endmodule

bind cmd_apb_bridge cmd_apb_bridge_chk #(
  .PADDR_W (PADDR_W),
  .TILE_LSB(TILE_LSB),
  .TILE_W  (TILE_W),
  .MARK_POS(MARK_POS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_we   (host_we),
  .host_rdata(host_rdata),
  .paddr     (paddr),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .pwdata    (pwdata),
  .pready    (pready),
  .pslverr   (pslverr)
);

// File: tb/cmd_apb_bridge_tb.sv
module cmd_apb_bridge_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [63:0] host_wdata = '0;
  logic [63:0] host_rdata;
  logic [31:0] paddr;
  logic        psel, penable, pwrite;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready = 1'b0;
  logic        pslverr = 1'b0;

  int checks = 0;
  int errors = 0;
  int wait_n = 0;
  bit err_req = 0;
  bit exp_err = 0;
  logic [63:0] exp_word = '0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  cmd_apb_bridge u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .paddr(paddr), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr)
  );

  function automatic logic [31:0] slave_data(logic [31:0] a);
    return a ^ 32'h5A3C_0F96;
  endfunction

  function automatic logic [28:0] norm_field(logic [28:0] f);
    logic [28:0] r = f;
    r[28] = (f[27:24] != 4'd0);
    return r;
  endfunction

  assign prdata = slave_data(paddr);

  // Bench slave: wait states and error on demand
  int wcnt = 0;
  always @(negedge clk) begin
    if (psel && penable) begin
      pready  <= (wcnt >= wait_n);
      pslverr <= (wcnt >= wait_n) ? err_req : 1'b0;
      wcnt    <= wcnt + 1;
    end else begin
      pready  <= 1'b0;
      pslverr <= 1'b0;
      wcnt    <= 0;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Run one command with GO=1; optional intruding host write mid-transfer.
  task automatic run_cmd(bit dir, logic [28:0] field, logic [31:0] data,
                         int waits, bit serr, bit intrude);
    logic [28:0] nf = norm_field(field);
    logic [31:0] eaddr = {1'b0, nf, 2'b00};
    int go_cycles = 0;
    int setups = 0;
    int accesses = 0;
    bit seen = 0;
    wait_n  = waits;
    err_req = serr;
    @(negedge clk);
    host_we    = 1'b1;
    host_wdata = {data, 1'b1, field, dir, 1'b1};
    @(negedge clk);
    host_we = 1'b0;
    check(host_rdata[0] == 1'b1 && psel == 1'b0, "R2 accept", host_rdata, 64'h1);
    check(host_rdata[31] == 1'b0, "R7 clear on launch", host_rdata[31], 0);
    check(host_rdata[30:2] == nf, "R6 normalised field", host_rdata[30:2], nf);
    for (int i = 0; i < 40 && host_rdata[0]; i++) begin
      go_cycles++;
      if (intrude && i == 2) begin
        host_we    = 1'b1;
        host_wdata = {~data, 1'b0, ~field, ~dir, 1'b1};
      end else begin
        host_we = 1'b0;
      end
      if (psel && !penable) begin
        setups++;
        check(i == 1, "R2 setup timing", i, 1);
      end
      if (psel && penable) accesses++;
      if (psel && !seen) begin
        seen = 1;
        check(paddr == eaddr, "R2 paddr", paddr, eaddr);
        check(pwrite == !dir, "R2 pwrite", pwrite, !dir);
        check(pwdata == data, "R5 pwdata", pwdata, data);
      end
      @(negedge clk);
    end
    host_we = 1'b0;
    check(setups == 1, "R8 single setup", setups, 1);
    check(accesses == waits + 1, "R3 access length", accesses, waits + 1);
    check(go_cycles == waits + 3, "R4 busy length", go_cycles, waits + 3);
    check(!psel && !penable, "R4 bus idle", {psel, penable}, 0);
    exp_err  = serr;
    exp_word = {(dir ? slave_data(eaddr) : data), serr, nf, dir, 1'b0};
    check(host_rdata == exp_word, "R5 R7 R8 readback", host_rdata, exp_word);
  endtask

  task automatic plain_write(logic [63:0] w);
    @(negedge clk);
    host_we    = 1'b1;
    host_wdata = {w[63:1], 1'b0};
    @(negedge clk);
    host_we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(!psel && !host_rdata[0], "R9 no launch", {psel, host_rdata[0]}, 0);
      @(negedge clk);
    end
    exp_word = {w[63:32], exp_err, norm_field(w[30:2]), w[1], 1'b0};
    check(host_rdata == exp_word, "R9 stored fields", host_rdata, exp_word);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(host_rdata == 64'd0, "R1 reset word", host_rdata, 0);
    check(!psel && !penable, "R1 bus idle", {psel, penable}, 0);

    // Directed corners
    run_cmd(1'b0, 29'h0000_0040, 32'hDEAD_BEEF, 0, 0, 0);      // root tile, write, no wait
    run_cmd(1'b1, 29'h1300_0010, 32'h0, 3, 0, 0);              // tile 3, read
    run_cmd(1'b1, 29'h1000_0020, 32'h1234_5678, 2, 0, 0);      // R6 tile 0 with stray marker
    run_cmd(1'b0, 29'h0F00_0004, 32'hCAFE_0001, 1, 1, 0);      // R6 tile 15 missing marker, R7 error
    plain_write({32'hAAAA_5555, 1'b0, 29'h0200_0008, 1'b1, 1'b0}); // R9 error kept
    plain_write({32'h0101_0202, 1'b1, 29'h0000_000C, 1'b0, 1'b0}); // R9 bit 31 ignored
    run_cmd(1'b1, 29'h0500_0100, 32'h0, 6, 0, 1);              // R8 intruding write
    run_cmd(1'b0, 29'h1700_0000, 32'h8000_0001, 7, 1, 1);      // R8 + R7

    // Random mix
    for (int n = 0; n < 60; n++) begin
      run_cmd(1'($urandom), 29'($urandom), $urandom, int'($urandom % 8),
              ($urandom % 4) == 0, ($urandom % 5) == 0);
    end
    done_flag = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done_flag; c++) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule